// File: doc/BRIEF.md
# Clocked controller for an asynchronous 32-bit static RAM

This block lets a synchronous host read and write an external asynchronous static RAM of 2^17 words by 32 bits. The RAM is split into four byte lanes, and each lane has its own active-low chip select. The host uses a level request. It holds the request, the read/write flag, the word address, the write data and the byte-enable mask steady until a one-cycle acknowledge returns. On the memory side the controller drives the address, the four lane selects, an active-low write strobe, an active-low output enable, the write data and an enable for the bidirectional data bus. The pad that combines `mem_dout`, `mem_dout_en` and `mem_din` sits outside this block.

Every strobe and bus-enable output comes straight from a flip-flop. Each access runs through fixed phases: an address-setup cycle with all strobes high, then either a write strobe followed by a recovery phase or a read access, and last a turnaround phase with the bus idle. The length of each phase, in clocks, is worked out at elaboration from the memory's limits in nanoseconds and the clock period. The rule is ceiling(limit / period), with a floor of one cycle. A parameter selects a variant that keeps output enable low through writes. In that variant the controller delays driving the bus and stretches the write pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `mem_we_n`, `mem_oe_n` and all of `mem_cs_n` are high, and `mem_dout_en` and `host_ack` are low.
- R2: `mem_addr` changes only while every lane select is high. During a write strobe it equals the `host_addr` of that request.
- R3: A write holds `mem_we_n` low for max(ceil(tWP), D + ceil(tDW)) cycles, where D is the drive delay: 1, or ceil(tHZ) in the R9 variant. The default is 3 cycles. `mem_cs_n[i]` is low exactly when `host_be[i]` is set, and byte enable bit i covers data bits 8i+7..8i. In the default mode `mem_oe_n` stays high throughout.
- R4: `mem_dout_en` is low in the first cycle of the write strobe. It is still high in the cycle after `mem_we_n` rises, so the data hold time is met.
- R5: A read drives all four lane selects and `mem_oe_n` low, with `mem_we_n` high, for max(ceil(tAA), ceil(tOE)) cycles (default 3). `host_rdata` is the bus value at the clock edge that closes the last of these cycles.
- R6: `host_ack` is a single-cycle pulse. It comes 2+P+C cycles after the accepting edge for a write and 2+A cycles for a read, where P is the pulse, C is the recovery and A is the access length. With the defaults that is 6 and 5.
- R7: During the acknowledge cycle the bus is quiet. After the acknowledge, at least ceil(tHZ)+1 cycles pass with all lane selects high before the next access strobes them (default 3). No request is taken during that time.
- R8: A write with a zero byte-enable mask asserts no lane select and leaves every stored byte unchanged.
- R9: With `OE_LOW_WR` set, `mem_oe_n` stays low through the write strobe. The bus is driven only after ceil(tHZ) strobe cycles. The pulse becomes max(ceil(tWP), ceil(tHZ)+ceil(tDW)), which is 4 at the default timing, and the write acknowledge comes 7 cycles after acceptance.
- R10: Every phase is a whole number of cycles of at least one. A 0 ns recovery limit still gives one recovery cycle, and a write cycle is never shorter than ceil(tWC) cycles counted from the address change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | LANES*LANE_W | Write data |
| host_be | input | LANES | Byte-lane enable mask for writes |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | LANES*LANE_W | Read data, valid from the acknowledge cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | LANES | Active-low chip select per byte lane |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dout | output | LANES*LANE_W | Data toward the memory |
| mem_dout_en | output | 1 | High while the controller drives the data bus |
| mem_din | input | LANES*LANE_W | Data from the memory |

## Verification
The assertions assume the host obeys the handshake: its request fields stay constant from the request until the acknowledge. They also assume `mem_din` has settled by the capturing edge whenever the access time has elapsed. The bench meets both conditions. It changes host inputs only at falling edges, drops or reissues a request only in the cycle that carries the acknowledge, and drives `mem_din` from a memory model. That model returns stored data only after the read strobes have been low for the access time in cycles and returns a poison word before then, so an early capture shows up as a data mismatch. The model also commits each write lane at the rising edge of the strobe, using the value seen in the last strobe cycle, and writes a poison byte if the bus was not driven then.

// File: rtl/sram_strobe_pkg.sv
`timescale 1ns/1ps
package sram_strobe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WSTROBE,
      ST_WRECOV,
      ST_RACCESS,
      ST_TURN
   } ctl_state_t;

   // whole clock cycles covering a limit in ns, never fewer than one
   function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] left,
   output logic             last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (load)
         left <= load_val - 1'b1;
      else if (left != '0)
         left <= left - 1'b1;
   end

   assign last = (left == '0);

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sel_wr,
   input  logic                      sel_rd,
   input  logic [LANES-1:0]          be,
   input  logic                      capture,
   input  logic [LANES*LANE_W-1:0]   din,
   output logic [LANES-1:0]          cs_n,
   output logic [LANES*LANE_W-1:0]   rdata
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic              cs_n_q;
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_n_q <= 1'b1;
            rd_q   <= '0;
         end else begin
            cs_n_q <= !((sel_wr && be[i]) || sel_rd);
            if (capture)
               rd_q <= din[i*LANE_W +: LANE_W];
         end
      end

      assign cs_n[i]                   = cs_n_q;
      assign rdata[i*LANE_W +: LANE_W] = rd_q;
   end

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
   import sram_strobe_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int LANES     = 4,
   parameter int LANE_W    = 8,
   parameter int CLK_NS    = 5,
   parameter int T_WP_NS   = 12,
   parameter int T_DW_NS   = 10,
   parameter int T_WR_NS   = 0,
   parameter int T_WC_NS   = 15,
   parameter int T_AA_NS   = 15,
   parameter int T_OE_NS   = 8,
   parameter int T_HZ_NS   = 8,
   parameter bit OE_LOW_WR = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_req,
   input  logic                    host_we,
   input  logic [ADDR_W-1:0]       host_addr,
   input  logic [LANES*LANE_W-1:0] host_wdata,
   input  logic [LANES-1:0]        host_be,
   output logic                    host_ack,
   output logic [LANES*LANE_W-1:0] host_rdata,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [LANES-1:0]        mem_cs_n,
   output logic                    mem_we_n,
   output logic                    mem_oe_n,
   output logic [LANES*LANE_W-1:0] mem_dout,
   output logic                    mem_dout_en,
   input  logic [LANES*LANE_W-1:0] mem_din
);

   localparam int DATA_W  = LANES * LANE_W;
   localparam int WP_C    = ns_to_cycles(T_WP_NS, CLK_NS);
   localparam int DW_C    = ns_to_cycles(T_DW_NS, CLK_NS);
   localparam int WR_C    = ns_to_cycles(T_WR_NS, CLK_NS);
   localparam int WC_C    = ns_to_cycles(T_WC_NS, CLK_NS);
   localparam int AA_C    = ns_to_cycles(T_AA_NS, CLK_NS);
   localparam int OE_C    = ns_to_cycles(T_OE_NS, CLK_NS);
   localparam int HZ_C    = ns_to_cycles(T_HZ_NS, CLK_NS);
   localparam int DRIVE_C = OE_LOW_WR ? HZ_C : 1;
   localparam int PULSE_C = imax(WP_C, DRIVE_C + DW_C);
   localparam int REC_C   = imax(WR_C, WC_C - 1 - PULSE_C);
   localparam int RD_C    = imax(AA_C, OE_C);
   localparam int TURN_C  = HZ_C;
   localparam int MAX_C   = imax(imax(PULSE_C, REC_C), imax(RD_C, TURN_C));
   localparam int TMR_W   = $clog2(MAX_C + 1);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("sram_strobe_ctrl: ADDR_W out of range");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("sram_strobe_ctrl: lane geometry must be positive");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_strobe_ctrl: CLK_NS must be at least 1");
   end

   ctl_state_t         state_q, state_d;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [LANES-1:0]   be_q;
   logic               op_we_q;
   logic               we_n_q, oe_n_q, dout_en_q, ack_q;
   logic               tmr_load, tmr_last;
   logic [TMR_W-1:0]   tmr_val, tmr_left;
   logic               accept, capture, drive_next, oe_low_next;

   assign accept = (state_q == ST_IDLE) && host_req;

   sram_phase_timer #(.CNT_W(TMR_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .left     (tmr_left),
      .last     (tmr_last)
   );

   // phase sequencing
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (host_req) state_d = ST_SETUP;
         end
         ST_SETUP: begin
            tmr_load = 1'b1;
            if (op_we_q) begin
               state_d = ST_WSTROBE;
               tmr_val = TMR_W'(PULSE_C);
            end else begin
               state_d = ST_RACCESS;
               tmr_val = TMR_W'(RD_C);
            end
         end
         ST_WSTROBE: begin
            if (tmr_last) begin
               state_d  = ST_WRECOV;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(REC_C);
            end
         end
         ST_WRECOV: begin
            if (tmr_last) begin
               state_d  = ST_TURN;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(TURN_C);
            end
         end
         ST_RACCESS: begin
            if (tmr_last) begin
               state_d  = ST_TURN;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(TURN_C);
               capture  = 1'b1;
            end
         end
         ST_TURN: begin
            if (tmr_last) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // bus driven from strobe cycle index DRIVE_C onward, held through recovery
   assign drive_next = (state_q == ST_WSTROBE) && (state_d == ST_WSTROBE) &&
                       ((PULSE_C - int'(tmr_left)) >= DRIVE_C);

   if (OE_LOW_WR) begin : g_oe_low_in_write
      assign oe_low_next = (state_d == ST_RACCESS) || (state_d == ST_WSTROBE);
   end else begin : g_oe_high_in_write
      assign oe_low_next = (state_d == ST_RACCESS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         wdata_q   <= '0;
         be_q      <= '0;
         op_we_q   <= 1'b0;
         we_n_q    <= 1'b1;
         oe_n_q    <= 1'b1;
         dout_en_q <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            be_q    <= host_be;
            op_we_q <= host_we;
         end
         we_n_q    <= !(state_d == ST_WSTROBE);
         oe_n_q    <= !oe_low_next;
         dout_en_q <= drive_next || (state_d == ST_WRECOV);
         ack_q     <= (state_d == ST_TURN) && (state_q != ST_TURN);
      end
   end

   sram_lane_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) i_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_wr  (state_d == ST_WSTROBE),
      .sel_rd  (state_d == ST_RACCESS),
      .be      (be_q),
      .capture (capture),
      .din     (mem_din),
      .cs_n    (mem_cs_n),
      .rdata   (host_rdata)
   );

   assign mem_addr    = addr_q;
   assign mem_dout    = wdata_q;
   assign mem_we_n    = we_n_q;
   assign mem_oe_n    = oe_n_q;
   assign mem_dout_en = dout_en_q;
   assign host_ack    = ack_q;

   // R2: address frozen while any lane is selected
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs_n != '1) |-> $stable(mem_addr));

   // R3: default mode never enables outputs under a write strobe
   p_we_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && !OE_LOW_WR) |-> mem_oe_n);

   // R4: no drive in the first strobe cycle
   p_first_nodrive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> !mem_dout_en);

   // R4: data held past the strobe's rising edge
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_dout_en);

   // R5: output enable with write strobe high selects every lane
   p_rd_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && mem_we_n) |-> (mem_cs_n == '0));

   // R6: acknowledge lasts one cycle
   p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);

   // R7: acknowledge cycle has a quiet bus
   p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |-> (mem_we_n && (mem_cs_n == '1) && !mem_dout_en));

   // R9: output enable low throughout a strobe in the variant
   if (OE_LOW_WR) begin : g_chk_oe_low
      p_oe_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !mem_we_n |-> !mem_oe_n);
   end

endmodule

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

   function automatic int cyc(input int t_ns);
      int c;
      c = (t_ns + 4) / 5;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_PULSE  = mx(cyc(12), 1 + cyc(10));
   localparam int E_REC    = mx(cyc(0), cyc(15) - 1 - E_PULSE);
   localparam int E_RD     = mx(cyc(15), cyc(8));
   localparam int E_TURN   = cyc(8);
   localparam int E_WLAT   = 2 + E_PULSE + E_REC;
   localparam int E_RLAT   = 2 + E_RD;
   localparam int E_PULSE2 = mx(cyc(12), cyc(8) + cyc(10));
   localparam int E_WLAT2  = 2 + E_PULSE2 + mx(cyc(0), cyc(15) - 1 - E_PULSE2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int vectors = 0;
   int fails   = 0;

   // instance under main test
   logic        req = 0, we = 0;
   logic [16:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  be = '0;
   logic        host_ack;
   logic [31:0] host_rdata, m_dout, m_din;
   logic [16:0] m_addr;
   logic [3:0]  m_cs_n;
   logic        m_we_n, m_oe_n, m_dout_en;

   sram_strobe_ctrl i_sram_strobe_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr),
      .host_wdata(wdata), .host_be(be), .host_ack(host_ack), .host_rdata(host_rdata),
      .mem_addr(m_addr), .mem_cs_n(m_cs_n), .mem_we_n(m_we_n), .mem_oe_n(m_oe_n),
      .mem_dout(m_dout), .mem_dout_en(m_dout_en), .mem_din(m_din)
   );

   // output-enable-low variant
   logic        b_req = 0, b_we = 0;
   logic        b_ack, b_we_n, b_oe_n, b_dout_en;
   logic [31:0] b_rdata, b_dout;
   logic [16:0] b_addr;
   logic [3:0]  b_cs_n;

   sram_strobe_ctrl #(.OE_LOW_WR(1'b1)) i_sram_strobe_ctrl_oelo (
      .clk(clk), .rst_n(rst_n), .host_req(b_req), .host_we(b_we), .host_addr(17'h1F0F0),
      .host_wdata(32'h1357_9BDF), .host_be(4'hF), .host_ack(b_ack), .host_rdata(b_rdata),
      .mem_addr(b_addr), .mem_cs_n(b_cs_n), .mem_we_n(b_we_n), .mem_oe_n(b_oe_n),
      .mem_dout(b_dout), .mem_dout_en(b_dout_en), .mem_din(32'hC0DE_F00D)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // memory model and bus monitor for the main instance
   logic [31:0] mem [16];
   logic [7:0]  lat [4];
   int          rd_cnt, wlen, gap, last_pulse, last_gap;
   logic        we_prev, gap_run, first_drive, oe_low_seen, hold_seen;
   logic [3:0]  st_cs;
   logic [16:0] st_addr;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] = '0;
         rd_cnt = 0; wlen = 0; gap = 0; gap_run = 0; we_prev = 1;
         last_pulse = -1; last_gap = -1; m_din = 32'hA5A5_5A5A;
      end else begin
         if (m_cs_n == 4'h0 && !m_oe_n && m_we_n) rd_cnt++; else rd_cnt = 0;
         if (!m_we_n) begin
            if (wlen == 0) begin first_drive = m_dout_en; oe_low_seen = 0; end
            wlen++;
            if (!m_oe_n) oe_low_seen = 1;
            st_cs = m_cs_n; st_addr = m_addr;
            for (int i = 0; i < 4; i++) lat[i] = m_dout_en ? m_dout[i*8 +: 8] : 8'hEE;
         end else if (!we_prev) begin
            last_pulse = wlen; wlen = 0; hold_seen = m_dout_en;
            for (int i = 0; i < 4; i++)
               if (!st_cs[i]) mem[st_addr[3:0]][i*8 +: 8] = lat[i];
         end
         we_prev = m_we_n;
         if (m_cs_n != 4'hF) begin
            if (gap_run) begin last_gap = gap; gap_run = 0; end
         end else if (gap_run) gap++;
         if (host_ack) begin gap_run = 1; gap = 0; end
         m_din = (rd_cnt >= E_RD) ? mem[m_addr[3:0]] : 32'hA5A5_5A5A;
      end
   end

   // monitor for the variant
   int   blen, b_pulse, b_nodrv;
   logic b_we_prev, b_oe_low;
   always @(negedge clk) begin
      if (!rst_n) begin
         blen = 0; b_pulse = -1; b_nodrv = 0; b_we_prev = 1; b_oe_low = 1;
      end else begin
         if (!b_we_n) begin
            if (blen == 0) begin b_oe_low = 1; b_nodrv = 0; end
            blen++;
            if (b_oe_n) b_oe_low = 0;
            if (!b_dout_en) b_nodrv++;
         end else if (!b_we_prev) begin
            b_pulse = blen; blen = 0;
         end
         b_we_prev = b_we_n;
      end
   end

   logic [31:0] shadow [16];

   // issue one access, return latency in negedges (entered at a negedge)
   task automatic run_op(input logic w, input logic [16:0] a, input logic [31:0] d,
                         input logic [3:0] m, output int n);
      req = 1; we = w; addr = a; wdata = d; be = m; n = 0;
      do begin
         @(negedge clk); n++;
      end while (!host_ack && n < 60);
      req = 0;
   endtask

   function automatic logic [16:0] addr_of(input int i);
      return {4'(i), 9'(i * 37 + 5), 4'(i)};
   endfunction

   function automatic logic [31:0] bmask(input logic [3:0] m);
      return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
   endfunction

   initial begin
      int n, extra;
      logic [31:0] pat;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 we_n", {31'd0, m_we_n}, 32'd1);
      check("R1 oe_n", {31'd0, m_oe_n}, 32'd1);
      check("R1 cs_n", {28'd0, m_cs_n}, 32'hF);
      check("R1 dout_en/ack", {30'd0, m_dout_en, host_ack}, 32'd0);
      rst_n = 1;
      @(negedge clk);
      extra = 0;
      // fill every word with all lanes enabled
      for (int i = 0; i < 16; i++) begin
         pat = (32'h1000_0001 * (i + 1)) ^ 32'h5A3C_9600;
         run_op(1'b1, addr_of(i), pat, 4'hF, n);
         shadow[i] = pat;
         check("R6 R10 write latency", n, E_WLAT + extra);
         check("R3 pulse length", last_pulse, E_PULSE);
         extra = E_TURN;
      end
      // partial writes under every mask, each read back
      for (int m = 0; m < 16; m++) begin
         pat = ~shadow[m] ^ {4{8'(m * 17 + 3)}};
         run_op(1'b1, addr_of(m), pat, 4'(m), n);
         check("R6 write latency", n, E_WLAT + E_TURN);
         check("R3 write pulse", last_pulse, E_PULSE);
         if (m != 0) begin
            check("R3 lane selects", {28'd0, st_cs}, {28'd0, ~4'(m)});
            check("R2 strobe address", {15'd0, st_addr}, {15'd0, addr_of(m)});
            check("R3 oe high in write", {31'd0, oe_low_seen}, 32'd0);
            check("R4 first cycle undriven", {31'd0, first_drive}, 32'd0);
            check("R4 hold after strobe", {31'd0, hold_seen}, 32'd1);
         end else begin
            check("R8 no lane selected", {28'd0, st_cs}, 32'hF);
         end
         shadow[m] = (shadow[m] & ~bmask(4'(m))) | (pat & bmask(4'(m)));
         run_op(1'b0, addr_of(m), 32'hFFFF_FFFF, 4'h0, n);
         check("R6 read latency", n, E_RLAT + E_TURN);
         check(m == 0 ? "R8 zero mask keeps data" : "R5 read data", host_rdata, shadow[m]);
         check("R7 quiet gap", last_gap, E_TURN + 1);
      end
      // R9: variant with output enable low during writes
      repeat (4) @(negedge clk);
      b_req = 1; b_we = 1; n = 0;
      do begin @(negedge clk); n++; end while (!b_ack && n < 60);
      b_req = 0;
      check("R9 write latency", n, E_WLAT2);
      check("R9 stretched pulse", b_pulse, E_PULSE2);
      check("R9 oe low in write", {31'd0, b_oe_low}, 32'd1);
      check("R9 undriven strobe cycles", b_nodrv, cyc(8));
      repeat (4) @(negedge clk);
      b_req = 1; b_we = 0; n = 0;
      do begin @(negedge clk); n++; end while (!b_ack && n < 60);
      b_req = 0;
      check("R9 read data", b_rdata, 32'hC0DE_F00D);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule